// File: doc/BRIEF.md
# Address Register with Stack Unit

This block holds a 12-bit address register for a small microcontroller core and every path that touches it. One register serves four purposes: a pointer for reading 16-bit constants out of program memory into a data buffer, the target of an indirect branch, the target of an indirect call, and a value that can be saved to and restored from an eight-entry address stack. The core issues one operation per cycle on a one-hot strobe vector. The block answers with a program memory read request, an updated data buffer, stack pointer movement, or a registered load request to the program counter.

The stack is shared with subroutine calls. An indirect call pushes the return address (current PC plus one) with the same rule as a register push. Pushes decrement the pointer before writing. Pops read at the current pointer and then increment it. Sticky flags record pushes past eight held entries and pops from an empty stack.

Strobe encoding on `op_i`: bit 0 table read, bit 1 push, bit 2 pop, bit 3 indirect branch, bit 4 indirect call, bit 5 increment, bit 6 load register from buffer, bit 7 copy register into buffer.

Top module: `addr_ptr_unit`

## Requirements
- R1: After reset the register, the data buffer, the stack pointer, every stack entry, both flags, `dbf_valid_o` and `pc_load_o` are all zero.
- R2: The increment strobe (`op_i` bit 5) adds one to the register, and FFFh becomes 000h.
- R3: In the cycle of a table read (`op_i` bit 0), `pmem_rd_o` is high and `pmem_addr_o` equals the register. The memory word arrives one cycle later, and at the next edge it is stored in the buffer while `dbf_valid_o` goes high for exactly one cycle.
- R4: A push (`op_i` bit 1) decrements the 3-bit stack pointer modulo 8 and writes the register into the entry the new pointer selects. The first push after reset leaves the pointer at 7.
- R5: A pop (`op_i` bit 2) loads the register from the entry at the current pointer and then increments the pointer modulo 8.
- R6: Values pushed are popped back in reverse order.
- R7: An indirect branch (`op_i` bit 3) raises `pc_load_o` for one cycle, starting the cycle after the strobe, with `pc_target_o` equal to the register value at the strobe.
- R8: An indirect call (`op_i` bit 4) acts like R7 and also pushes `pc_i + 1` (modulo 4096) by the R4 rule.
- R9: The load strobe (`op_i` bit 6) copies bits 11:0 of the buffer into the register and drops bits 15:12.
- R10: The copy strobe (`op_i` bit 7) writes the register, zero-extended to 16 bits, into the buffer without raising `dbf_valid_o`.
- R11: A push or call made while eight entries are held sets `ovf_o`, which stays set until reset. The write still takes place.
- R12: A pop made while no entry is held sets `unf_o`, which stays set until reset. The pop still moves the register and the pointer.
- R13: With no strobe the register, buffer and pointer hold, and `pc_load_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 8 | One-hot operation strobes |
| pc_i | input | 12 | Current program counter |
| pmem_data_i | input | 16 | Program memory read data, one cycle after request |
| pmem_rd_o | output | 1 | Program memory read request |
| pmem_addr_o | output | 12 | Program memory read address |
| pc_load_o | output | 1 | Program counter load request |
| pc_target_o | output | 12 | Program counter load value |
| ar_o | output | 12 | Address register |
| dbf_o | output | 16 | Data buffer |
| dbf_valid_o | output | 1 | Fetched word captured in buffer |
| sp_o | output | 3 | Stack pointer |
| ovf_o | output | 1 | Sticky stack overflow |
| unf_o | output | 1 | Sticky stack underflow |

## Verification
The assertions assume that at most one bit of `op_i` is set in a cycle. They also assume that no copy-into-buffer strobe follows a table read in the next cycle, because that cycle belongs to the buffer capture. The bench drives each strobe for a single cycle and returns `op_i` to zero before the next one. It always waits one extra idle cycle after a table read before it issues any other operation that touches the buffer.

// File: rtl/aptr_pkg.sv
package aptr_pkg;
  localparam int OP_W    = 8;
  localparam int OP_TRD  = 0;
  localparam int OP_PUSH = 1;
  localparam int OP_POP  = 2;
  localparam int OP_BR   = 3;
  localparam int OP_CALL = 4;
  localparam int OP_INC  = 5;
  localparam int OP_LDA  = 6;
  localparam int OP_STA  = 7;
endpackage

// File: rtl/aptr_areg.sv
module aptr_areg #(
  parameter int AW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          pop_i,
  input  logic          lda_i,
  input  logic          br_i,
  input  logic          call_i,
  input  logic [AW-1:0] pop_data_i,
  input  logic [AW-1:0] dbf_lo_i,
  output logic [AW-1:0] ar_o,
  output logic          pc_load_o,
  output logic [AW-1:0] pc_target_o
);
  logic [AW-1:0] ar_q, ar_d;
  logic          ld_q;
  logic [AW-1:0] tgt_q;

  always_comb begin
    ar_d = ar_q;
    if (inc_i)      ar_d = ar_q + AW'(1);
    else if (pop_i) ar_d = pop_data_i;
    else if (lda_i) ar_d = dbf_lo_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ar_q  <= '0;
      ld_q  <= 1'b0;
      tgt_q <= '0;
    end else begin
      ar_q <= ar_d;
      ld_q <= br_i | call_i;
      if (br_i | call_i) tgt_q <= ar_q;
    end
  end

  assign ar_o        = ar_q;
  assign pc_load_o   = ld_q;
  assign pc_target_o = tgt_q;
endmodule

// File: rtl/aptr_stack.sv
module aptr_stack #(
  parameter int AW    = 12,
  parameter int DEPTH = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      push_i,
  input  logic                      pop_i,
  input  logic [AW-1:0]             wdata_i,
  output logic [AW-1:0]             rdata_o,
  output logic [$clog2(DEPTH)-1:0]  sp_o,
  output logic                      ovf_o,
  output logic                      unf_o
);
  localparam int SPW = $clog2(DEPTH);
  localparam int CW  = $clog2(DEPTH + 1);

  logic [AW-1:0]  stk_q [DEPTH];
  logic [SPW-1:0] sp_q, wr_idx;
  logic [CW-1:0]  cnt_q;
  logic           ovf_q, unf_q;
  logic           full, empty;

  assign wr_idx = sp_q - SPW'(1);
  assign full   = (cnt_q == CW'(DEPTH));
  assign empty  = (cnt_q == '0);

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              stk_q[e] <= '0;
      else if (push_i && wr_idx == SPW'(e))     stk_q[e] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      if (push_i) begin
        sp_q <= wr_idx;
        if (full) ovf_q <= 1'b1;
        else      cnt_q <= cnt_q + CW'(1);
      end else if (pop_i) begin
        sp_q <= sp_q + SPW'(1);
        if (empty) unf_q <= 1'b1;
        else       cnt_q <= cnt_q - CW'(1);
      end
    end
  end

  assign rdata_o = stk_q[sp_q];
  assign sp_o    = sp_q;
  assign ovf_o   = ovf_q;
  assign unf_o   = unf_q;
endmodule

// File: rtl/aptr_dbuf.sv
module aptr_dbuf #(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          trd_i,
  input  logic          sta_i,
  input  logic [AW-1:0] ar_i,
  input  logic [DW-1:0] pmem_data_i,
  output logic [DW-1:0] dbf_o,
  output logic          valid_o
);
  logic          pend_q;
  logic          val_q;
  logic [DW-1:0] dbf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      val_q  <= 1'b0;
      dbf_q  <= '0;
    end else begin
      pend_q <= trd_i;
      val_q  <= pend_q;
      // memory return owns the buffer in its capture cycle
      if (pend_q)     dbf_q <= pmem_data_i;
      else if (sta_i) dbf_q <= DW'(ar_i);
    end
  end

  assign dbf_o   = dbf_q;
  assign valid_o = val_q;
endmodule

// File: rtl/addr_ptr_unit.sv
module addr_ptr_unit
  import aptr_pkg::*;
#(
  parameter int AW    = 12,
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [OP_W-1:0]           op_i,
  input  logic [AW-1:0]             pc_i,
  input  logic [DW-1:0]             pmem_data_i,
  output logic                      pmem_rd_o,
  output logic [AW-1:0]             pmem_addr_o,
  output logic                      pc_load_o,
  output logic [AW-1:0]             pc_target_o,
  output logic [AW-1:0]             ar_o,
  output logic [DW-1:0]             dbf_o,
  output logic                      dbf_valid_o,
  output logic [$clog2(DEPTH)-1:0]  sp_o,
  output logic                      ovf_o,
  output logic                      unf_o
);
  logic [AW-1:0] ar, stk_rdata, stk_wdata;
  logic [DW-1:0] dbf;
  logic          stk_push;

  assign stk_push  = op_i[OP_PUSH] | op_i[OP_CALL];
  assign stk_wdata = op_i[OP_CALL] ? pc_i + AW'(1) : ar;

  aptr_areg #(.AW(AW)) u_areg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .inc_i       (op_i[OP_INC]),
    .pop_i       (op_i[OP_POP]),
    .lda_i       (op_i[OP_LDA]),
    .br_i        (op_i[OP_BR]),
    .call_i      (op_i[OP_CALL]),
    .pop_data_i  (stk_rdata),
    .dbf_lo_i    (dbf[AW-1:0]),
    .ar_o        (ar),
    .pc_load_o   (pc_load_o),
    .pc_target_o (pc_target_o)
  );

  aptr_stack #(.AW(AW), .DEPTH(DEPTH)) u_stack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (stk_push),
    .pop_i   (op_i[OP_POP]),
    .wdata_i (stk_wdata),
    .rdata_o (stk_rdata),
    .sp_o    (sp_o),
    .ovf_o   (ovf_o),
    .unf_o   (unf_o)
  );

  aptr_dbuf #(.AW(AW), .DW(DW)) u_dbuf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .trd_i       (op_i[OP_TRD]),
    .sta_i       (op_i[OP_STA]),
    .ar_i        (ar),
    .pmem_data_i (pmem_data_i),
    .dbf_o       (dbf),
    .valid_o     (dbf_valid_o)
  );

  assign pmem_rd_o   = op_i[OP_TRD];
  assign pmem_addr_o = ar;
  assign ar_o        = ar;
  assign dbf_o       = dbf;
endmodule

// File: rtl/aptr_chk.sv
module aptr_chk
  import aptr_pkg::*;
#(
  parameter int AW  = 12,
  parameter int SPW = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [OP_W-1:0] op_i,
  input logic [AW-1:0]   ar_o,
  input logic [AW-1:0]   pc_target_o,
  input logic            pc_load_o,
  input logic            dbf_valid_o,
  input logic [SPW-1:0]  sp_o,
  input logic            ovf_o,
  input logic            unf_o
);
  p_op_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(op_i));

  p_no_sta_after_trd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i[OP_TRD] |=> !op_i[OP_STA]);

  p_inc_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i[OP_INC] |=> ar_o == AW'($past(ar_o) + AW'(1)));

  p_valid_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbf_valid_o |-> $past(op_i[OP_TRD], 2));

  p_push_sp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i[OP_PUSH] || op_i[OP_CALL]) |=> sp_o == SPW'($past(sp_o) - SPW'(1)));

  p_pop_sp_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i[OP_POP] |=> sp_o == SPW'($past(sp_o) + SPW'(1)));

  p_branch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i[OP_BR] || op_i[OP_CALL]) |=> pc_load_o && pc_target_o == $past(ar_o));

  p_load_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o |-> $past(op_i[OP_BR] || op_i[OP_CALL]));

  p_ovf_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);

  p_unf_sticky_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |=> unf_o);

  p_idle_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == '0) |=> $stable(ar_o) && $stable(sp_o) && !pc_load_o);
endmodule

bind addr_ptr_unit aptr_chk #(.AW(AW), .SPW($clog2(DEPTH))) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .op_i        (op_i),
  .ar_o        (ar_o),
  .pc_target_o (pc_target_o),
  .pc_load_o   (pc_load_o),
  .dbf_valid_o (dbf_valid_o),
  .sp_o        (sp_o),
  .ovf_o       (ovf_o),
  .unf_o       (unf_o)
);

// File: tb/addr_ptr_unit_tb.sv
`timescale 1ns/1ps
module addr_ptr_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  op_i = '0;
  logic [11:0] pc_i = '0;
  logic [15:0] pmem_data_i;
  logic        pmem_rd_o, pc_load_o, dbf_valid_o, ovf_o, unf_o;
  logic [11:0] pmem_addr_o, pc_target_o, ar_o;
  logic [15:0] dbf_o;
  logic [2:0]  sp_o;

  int errs = 0, checks = 0;
  bit done = 0;
  logic        poke_en = 1'b0;
  logic [15:0] poke_word = '0;

  localparam logic [7:0] TRD = 8'h01, PUSH = 8'h02, POP = 8'h04, BR = 8'h08,
                         CALL = 8'h10, INC = 8'h20, LDA = 8'h40, STA = 8'h80;

  always #5 clk_i = ~clk_i;

  addr_ptr_unit u_dut (.*);

  function automatic logic [15:0] word_at(logic [11:0] a);
    return {a[3:0], a ^ 12'hC35};
  endfunction

  always @(posedge clk_i)
    if (pmem_rd_o) pmem_data_i <= poke_en ? poke_word : word_at(pmem_addr_o);

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i) rst_ni = 1'b0; op_i = '0;
    @(negedge clk_i) rst_ni = 1'b1;
  endtask

  task automatic do_op(logic [7:0] op);
    @(negedge clk_i) op_i = op;
    @(negedge clk_i) op_i = '0;
  endtask

  task automatic set_ar(logic [11:0] v);
    poke_en = 1'b1; poke_word = {4'hE, v};
    do_op(TRD);
    @(negedge clk_i);
    poke_en = 1'b0;
    do_op(LDA);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 ar", 16'(ar_o), 16'h0);
    chk("R1 dbf", dbf_o, 16'h0);
    chk("R1 flags", {11'b0, sp_o, ovf_o, unf_o}, 16'h0);
    chk("R1 strobes", {14'b0, pc_load_o, dbf_valid_o}, 16'h0);
  endtask

  task automatic t_inc_wrap();
    do_reset();
    do_op(INC);
    chk("R2 inc", 16'(ar_o), 16'h001);
    set_ar(12'hFFE);
    do_op(INC);
    chk("R2 inc ffe", 16'(ar_o), 16'h0FFF);
    do_op(INC);
    chk("R2 wrap", 16'(ar_o), 16'h0000);
  endtask

  task automatic t_table();
    do_reset();
    set_ar(12'h3A7);
    @(negedge clk_i) op_i = TRD;
    #1;
    chk("R3 rd", 16'(pmem_rd_o), 16'h1);
    chk("R3 addr", 16'(pmem_addr_o), 16'h03A7);
    @(negedge clk_i) op_i = '0;
    chk("R3 early valid", 16'(dbf_valid_o), 16'h0);
    chk("R3 early dbf", dbf_o, 16'hE3A7);
    @(negedge clk_i);
    chk("R3 valid", 16'(dbf_valid_o), 16'h1);
    chk("R3 word", dbf_o, word_at(12'h3A7));
    @(negedge clk_i);
    chk("R3 valid pulse", 16'(dbf_valid_o), 16'h0);
  endtask

  task automatic t_push_pop();
    do_reset();
    set_ar(12'h123);
    do_op(PUSH);
    chk("R4 first push sp", 16'(sp_o), 16'h7);
    set_ar(12'hABC);
    do_op(PUSH);
    chk("R4 sp", 16'(sp_o), 16'h6);
    do_op(INC);
    do_op(POP);
    chk("R5 pop ar", 16'(ar_o), 16'h0ABC);
    chk("R5 pop sp", 16'(sp_o), 16'h7);
    do_op(POP);
    chk("R6 lifo ar", 16'(ar_o), 16'h0123);
    chk("R6 lifo sp", 16'(sp_o), 16'h0);
    chk("R6 no flags", {14'b0, ovf_o, unf_o}, 16'h0);
  endtask

  task automatic t_branch();
    do_reset();
    set_ar(12'h7D2);
    do_op(BR);
    chk("R7 load", 16'(pc_load_o), 16'h1);
    chk("R7 target", 16'(pc_target_o), 16'h07D2);
    chk("R7 sp", 16'(sp_o), 16'h0);
    @(negedge clk_i);
    chk("R7 one pulse", 16'(pc_load_o), 16'h0);
  endtask

  task automatic t_call();
    do_reset();
    set_ar(12'h456);
    pc_i = 12'hFFF;
    do_op(CALL);
    chk("R8 load", 16'(pc_load_o), 16'h1);
    chk("R8 target", 16'(pc_target_o), 16'h0456);
    chk("R8 sp", 16'(sp_o), 16'h7);
    @(negedge clk_i);
    chk("R8 one pulse", 16'(pc_load_o), 16'h0);
    pc_i = 12'h000;
    do_op(POP);
    chk("R8 return addr", 16'(ar_o), 16'h0000);
    chk("R8 ar kept", 16'(pc_target_o), 16'h0456);
  endtask

  task automatic t_xfer();
    do_reset();
    set_ar(12'h5E1);
    chk("R9 load low", 16'(ar_o), 16'h05E1);
    do_op(INC);
    do_op(STA);
    chk("R10 copy", dbf_o, 16'h05E2);
    chk("R10 no valid", 16'(dbf_valid_o), 16'h0);
    @(negedge clk_i);
    chk("R10 no valid later", 16'(dbf_valid_o), 16'h0);
    poke_en = 1'b1; poke_word = 16'hF789;
    do_op(TRD);
    @(negedge clk_i);
    poke_en = 1'b0;
    do_op(LDA);
    chk("R9 drop high", 16'(ar_o), 16'h0789);
  endtask

  task automatic t_idle();
    do_reset();
    set_ar(12'h2B4);
    do_op(PUSH);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i);
      chk("R13 ar", 16'(ar_o), 16'h02B4);
      chk("R13 sp/load", {12'b0, sp_o, pc_load_o}, {12'b0, 3'd7, 1'b0});
    end
    chk("R13 dbf", dbf_o, 16'hE2B4);
  endtask

  task automatic t_overflow();
    do_reset();
    for (int i = 0; i < 8; i++) begin
      do_op(PUSH);
      do_op(INC);
    end
    chk("R11 full no ovf", 16'(ovf_o), 16'h0);
    chk("R11 sp full", 16'(sp_o), 16'h0);
    do_op(PUSH);
    chk("R11 ovf", 16'(ovf_o), 16'h1);
    chk("R11 sp wrap", 16'(sp_o), 16'h7);
    do_op(INC);
    do_op(POP);
    chk("R11 write done", 16'(ar_o), 16'h0008);
    repeat (3) @(negedge clk_i);
    chk("R11 sticky", 16'(ovf_o), 16'h1);
  endtask

  task automatic t_underflow();
    do_reset();
    do_op(INC);
    do_op(POP);
    chk("R12 unf", 16'(unf_o), 16'h1);
    chk("R12 ar", 16'(ar_o), 16'h0000);
    chk("R12 sp", 16'(sp_o), 16'h1);
    do_op(PUSH);
    chk("R12 sticky", 16'(unf_o), 16'h1);
    chk("R12 no ovf", 16'(ovf_o), 16'h0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_inc_wrap();
    t_table();
    t_push_pop();
    t_branch();
    t_call();
    t_xfer();
    t_idle();
    t_overflow();
    t_underflow();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule